// File: doc/BRIEF.md
# Flash Page ECC Syndrome Corrector

This block judges a 512-byte flash data block by comparing two 3-byte Hamming row/column parity codes: the one read back from the page's spare area (spare bytes 0, 1 and 2) and the one recomputed over the data as it was read. From the difference it works out one of four outcomes. The data is clean. The data has one flipped bit that can be repaired. The stored code itself took a hit. The damage is beyond repair.

When the outcome is a repairable data bit, the block also gives the 9-bit byte offset and the 3-bit bit position of the bad bit, so the surrounding logic can flip it in its buffer. A caller presents both codes with a one-cycle `in_valid` strobe. One clock later the registered verdict appears, together with a single-cycle `done` pulse. The `ignore_unset` input lets pages whose stored code was never written (all ones) pass as clean.

Top module: `ecc_fix_top`

## Requirements
- R1: The syndrome is the bytewise XOR of stored and recomputed codes, with code bits [7:0] as spare byte 0, [15:8] as byte 1 and [23:16] as byte 2 (syndrome bytes d0, d1, d2). An all-zero syndrome gives status 0 (clean).
- R2: When `ignore_unset` is 1 and the stored code is 24'hFFFFFF, status is 0 whatever the recomputed code is. When `ignore_unset` is 0, the same inputs are classified by R1, R3, R6 and R7.
- R3: If in each of d0, d1 and d2 every bit pair (bits 2i+1 and 2i) holds differing values, the status is 1 (data bit corrected).
- R4: For status 1, `bit_idx` equals {d2[7], d2[5], d2[3]}, MSB first.
- R5: For status 1, `byte_idx` equals {d2[1], d1[7], d1[5], d1[3], d1[1], d0[7], d0[5], d0[3], d0[1]}, MSB first.
- R6: A nonzero syndrome that fails R3 and has exactly one bit set gives status 2 (error in the stored code field).
- R7: Every other syndrome gives status 3 (uncorrectable).
- R8: `byte_idx` and `bit_idx` are zero whenever the status is not 1.
- R9: `done` is high for exactly the cycle after each `in_valid` cycle, and the outputs then carry that request's verdict. Without `in_valid`, `status`, `byte_idx` and `bit_idx` hold their values.
- R10: During and right after reset, `done`, `status`, `byte_idx` and `bit_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one cycle per code pair |
| stored_code | input | 24 | Code read from spare bytes 0..2, byte 0 in bits [7:0] |
| calc_code | input | 24 | Code recomputed over the data block, same byte order |
| ignore_unset | input | 1 | Treat an all-ones stored code as a clean page |
| done | output | 1 | One-cycle pulse marking a new verdict |
| status | output | 2 | 0 clean, 1 data bit corrected, 2 code-field error, 3 uncorrectable |
| byte_idx | output | 9 | Byte offset of the failing data bit |
| bit_idx | output | 3 | Bit position inside that byte |

## Verification
Correctable syndromes are built by encoding a chosen byte offset and bit position into pair patterns. This shows whether the index extraction recovers exactly that location, and each of the 12 pairs takes both orientations. Single-bit syndromes over all 24 positions separate the code-field case from clean and from uncorrectable. Random syndromes and near-miss patterns, with one pair broken, probe the boundary of the pair test. An all-ones stored code is applied with `ignore_unset` both set and clear, which shows that the bypass only applies when requested. Gaps between strobes check that `done` pulses once and that the outputs hold.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int BYTE_W     = 8;
  localparam int NBYTES     = 3;
  localparam int SYN_W      = BYTE_W * NBYTES;
  localparam int BYTE_IDX_W = 9;
  localparam int BIT_IDX_W  = 3;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_DATA  = 2'd1,
    ST_FIELD = 2'd2,
    ST_BAD   = 2'd3
  } fix_status_e;

  // every odd/even bit pair of a syndrome byte holds opposite values
  function automatic logic pairs_split(input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] x;
    x = d ^ (d >> 1);
    return (x & 8'h55) == 8'h55;
  endfunction

  function automatic logic [BYTE_IDX_W-1:0] pick_byte_idx(input logic [SYN_W-1:0] s);
    return {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]};
  endfunction

  function automatic logic [BIT_IDX_W-1:0] pick_bit_idx(input logic [SYN_W-1:0] s);
    return {s[23], s[21], s[19]};
  endfunction
endpackage

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_fix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYN_W-1:0] stored_code,
  input  logic [SYN_W-1:0] calc_code,
  input  logic             ignore_unset,
  output logic [SYN_W-1:0] syn,
  output logic             is_zero,
  output logic             is_unset,
  output logic             is_split,
  output logic             is_single
);
  logic [NBYTES-1:0] byte_split;

  assign syn = stored_code ^ calc_code;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign byte_split[g] = pairs_split(syn[g*BYTE_W +: BYTE_W]);
  end

  assign is_zero   = (syn == '0);
  assign is_unset  = ignore_unset && (stored_code == {SYN_W{1'b1}});
  assign is_split  = &byte_split;
  assign is_single = !is_zero && ((syn & (syn - 1'b1)) == '0);

  // R3: a splitting syndrome always carries one set bit per pair
  assert_split_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_split |-> ($countones(syn) == SYN_W/2));
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_fix_pkg::*;
(
  input  logic        is_zero,
  input  logic        is_unset,
  input  logic        is_split,
  input  logic        is_single,
  output fix_status_e verdict
);
  always_comb begin
    if (is_zero || is_unset)   verdict = ST_CLEAN;
    else if (is_split)         verdict = ST_DATA;
    else if (is_single)        verdict = ST_FIELD;
    else                       verdict = ST_BAD;
  end
endmodule

// File: rtl/ecc_locator.sv
module ecc_locator
  import ecc_fix_pkg::*;
(
  input  logic [SYN_W-1:0]      syn,
  input  fix_status_e           verdict,
  output logic [BYTE_IDX_W-1:0] byte_loc,
  output logic [BIT_IDX_W-1:0]  bit_loc
);
  logic use_loc;
  assign use_loc  = (verdict == ST_DATA);
  assign byte_loc = use_loc ? pick_byte_idx(syn) : '0;
  assign bit_loc  = use_loc ? pick_bit_idx(syn)  : '0;
endmodule

// File: rtl/ecc_fix_top.sv
module ecc_fix_top
  import ecc_fix_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [SYN_W-1:0]      stored_code,
  input  logic [SYN_W-1:0]      calc_code,
  input  logic                  ignore_unset,
  output logic                  done,
  output logic [1:0]            status,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [BIT_IDX_W-1:0]  bit_idx
);
  logic [SYN_W-1:0]      syn;
  logic                  is_zero, is_unset, is_split, is_single;
  fix_status_e           verdict;
  logic [BYTE_IDX_W-1:0] byte_loc;
  logic [BIT_IDX_W-1:0]  bit_loc;

  ecc_syndrome u_syn (
    .clk(clk), .rst_n(rst_n),
    .stored_code(stored_code), .calc_code(calc_code), .ignore_unset(ignore_unset),
    .syn(syn), .is_zero(is_zero), .is_unset(is_unset),
    .is_split(is_split), .is_single(is_single)
  );

  ecc_classify u_cls (
    .is_zero(is_zero), .is_unset(is_unset), .is_split(is_split),
    .is_single(is_single), .verdict(verdict)
  );

  ecc_locator u_loc (
    .syn(syn), .verdict(verdict), .byte_loc(byte_loc), .bit_loc(bit_loc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= 2'd0;
      byte_idx <= '0;
      bit_idx  <= '0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        status   <= verdict;
        byte_idx <= byte_loc;
        bit_idx  <= bit_loc;
      end
    end
  end

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(status) && $stable(byte_idx) && $stable(bit_idx)));
  assert_idx_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_DATA) |-> (byte_idx == '0 && bit_idx == '0));
  assert_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stored_code == calc_code) |=> (status == ST_CLEAN));
  assert_unset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ignore_unset && stored_code == {SYN_W{1'b1}}) |=> (status == ST_CLEAN));
endmodule

// File: tb/sim_ecc_fix_top.sv
`timescale 1ns/1ps
module sim_ecc_fix_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        ignore_unset = 1'b0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  byte_idx;
  logic [2:0]  bit_idx;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ecc_fix_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .stored_code(stored_code), .calc_code(calc_code), .ignore_unset(ignore_unset),
    .done(done), .status(status), .byte_idx(byte_idx), .bit_idx(bit_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // build a syndrome that encodes a data-bit location pair by pair
  function automatic logic [23:0] encode_loc(input int byt, input int bitp);
    logic [23:0] s = '0;
    logic [11:0] v;
    v = {bitp[2:0], byt[8:0]};
    for (int p = 0; p < 12; p++) begin
      if (v[p]) s[2*p+1] = 1'b1;
      else      s[2*p]   = 1'b1;
    end
    return s;
  endfunction

  function automatic int ones(input logic [23:0] s);
    int n = 0;
    for (int i = 0; i < 24; i++) n += s[i];
    return n;
  endfunction

  function automatic int exp_status(input logic [23:0] st, input logic [23:0] ca, input bit ign);
    logic [23:0] s;
    bit split = 1'b1;
    s = st ^ ca;
    if (s == 0) return 0;
    if (ign && st == 24'hFFFFFF) return 0;
    for (int p = 0; p < 12; p++) if (s[2*p] == s[2*p+1]) split = 1'b0;
    if (split) return 1;
    if (ones(s) == 1) return 2;
    return 3;
  endfunction

  function automatic int exp_byte(input logic [23:0] s);
    int r = 0;
    for (int p = 0; p < 9; p++) r |= int'(s[2*p+1]) << p;
    return r;
  endfunction

  function automatic int exp_bit(input logic [23:0] s);
    int r = 0;
    for (int p = 0; p < 3; p++) r |= int'(s[2*(p+9)+1]) << p;
    return r;
  endfunction

  task automatic apply(input logic [23:0] st, input logic [23:0] ca, input bit ign, input string tag);
    int es, eb, ek;
    es = exp_status(st, ca, ign);
    eb = (es == 1) ? exp_byte(st ^ ca) : 0;
    ek = (es == 1) ? exp_bit(st ^ ca) : 0;
    @(negedge clk);
    stored_code = st; calc_code = ca; ignore_unset = ign; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    stored_code = $urandom; calc_code = $urandom;
    check({tag, " R9 done"}, done, 1);
    check({tag, " status R1/R2/R3/R6/R7"}, status, es);
    check({tag, " byte R5/R8"}, byte_idx, eb);
    check({tag, " bit R4/R8"}, bit_idx, ek);
    @(negedge clk);
    check({tag, " R9 pulse"}, done, 0);
    check({tag, " R9 hold"}, status, es);
    check({tag, " R9 hold byte"}, byte_idx, eb);
  endtask

  initial begin
    logic [23:0] base, s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10 done", done, 0);
    check("R10 status", status, 0);
    check("R10 byte", byte_idx, 0);
    check("R10 bit", bit_idx, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {status, byte_idx, bit_idx, done}, 0);

    // R1 clean
    apply(24'h123456, 24'h123456, 1'b0, "R1 equal");
    // R4/R5 corner locations
    apply(24'h0, encode_loc(0, 0), 1'b0, "R5 loc0");
    apply(24'h0, encode_loc(511, 7), 1'b0, "R4 locmax");
    apply(24'hA5C3F0, 24'hA5C3F0 ^ encode_loc(256, 4), 1'b0, "R5 loc256");
    // R2 unset code
    apply(24'hFFFFFF, 24'h0F1E2D, 1'b1, "R2 ignored");
    apply(24'hFFFFFF, 24'h0F1E2D, 1'b0, "R2 not ignored");
    apply(24'hFFFFFF, 24'hFFFFFF ^ encode_loc(77, 2), 1'b0, "R2 off data");
    // R6 every single-bit syndrome
    for (int i = 0; i < 24; i++) apply(24'h3C3C3C, 24'h3C3C3C ^ (24'h1 << i), 1'b0, "R6 single");
    // R7 near miss: one pair broken
    s = encode_loc(300, 5); s[6] = ~s[6];
    apply(24'h0, s, 1'b0, "R7 broken pair");
    apply(24'h0, 24'h000003, 1'b0, "R7 two bits");
    apply(24'h0, 24'hFFFFFF, 1'b0, "R7 all ones syn");
    // random mix
    for (int n = 0; n < 300; n++) begin
      base = $urandom;
      case ($urandom_range(0, 3))
        0: s = '0;
        1: s = encode_loc($urandom_range(0, 511), $urandom_range(0, 7));
        2: s = 24'h1 << $urandom_range(0, 23);
        default: s = $urandom;
      endcase
      if ($urandom_range(0, 7) == 0) base = 24'hFFFFFF;
      apply(base, base ^ s, $urandom_range(0, 1), "rand R3");
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog R9 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule